// File: doc/BRIEF.md
# Paged Half-Word Register Bridge

This block sits behind a management serial port that offers only sixteen-bit registers and a five-bit register number. Through that narrow window it lets a host reach a space of thirty-two-bit internal registers. The serial framing is handled elsewhere. Here the block sees one parallel strobe per register access. Each strobe carries a device number, a register number, a write flag and sixteen bits of write data.

The bridge answers only on device number 0x1F. Register 0x1F holds a ten-bit page, which becomes bits 15:6 of the internal byte address. Registers 0x00 to 0x0F carry the lower half of a word, and their number supplies address bits 5:2. Register 0x10 carries the upper half. To write, the host sets the page, writes the lower half, then writes the upper half; the full word is committed on the upper-half write. To read, the host sets the page, reads the lower half, then reads the upper half. The upper half comes from the same fetch as the lower half. A small internal word array stands in for the register space that a real chip would attach.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the read data is 0x0000, the page is 0, and the staged lower half and the latched upper half are 0; reading register 0x10 or 0x1F before any write returns 0x0000.
- R2: A strobe on any device number other than 0x1F changes no state and commits nothing; a read on such a device returns 0xFFFF.
- R3: A write to register 0x1F loads the page from write-data bits 9:0 and drops bits 15:10; a read of register 0x1F returns the page zero-extended to sixteen bits.
- R4: The internal byte address is the page in bits 15:6, the lower-half register number in bits 5:2, and zero in bits 1:0.
- R5: A write to a register in 0x00..0x0F stages the data and the word address. The next write to register 0x10 raises the internal write strobe during that same strobe cycle, with data {upper, staged lower}, and the word is stored at the clock edge that ends the cycle.
- R6: A write to register 0x10 commits nothing unless a lower half has been staged since the last commit, so two upper-half writes in a row commit at most once.
- R7: Changing the page between the lower-half write and the upper-half write does not move the commit; the word goes to the address latched with the lower half.
- R8: A read of a register in 0x00..0x0F returns bits 15:0 of the addressed word and latches bits 31:16. A later read of register 0x10 returns that latched half, even if the word has been rewritten in between.
- R9: Registers 0x11 to 0x1E on device 0x1F read as 0x0000, and writes to them have no effect.
- R10: Word addresses at or beyond the array depth (32 words by default) discard writes and read as zero.
- R11: The read data changes only at the clock edge that ends a read strobe; it holds its value through write strobes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdio_req | input | 1 | One-cycle access strobe |
| mdio_wr | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | Device number of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write half-word |
| mdio_rdata | output | 16 | Read half-word, registered |
| int_we | output | 1 | Internal write strobe, high during a committing strobe cycle |
| int_addr | output | 16 | Internal byte address of the commit |
| int_wdata | output | 32 | Internal write word |

## Verification
The bench goes after the ordering hazards of the half-word protocol. If the bridge formed its commit address from the live page, a page write between the two halves (R7) would send the word to the wrong location. If the upper half were fetched again on a register 0x10 read, a rewrite between the two reads (R8) would return a torn word. If the stage were never disarmed, a repeated upper-half write (R6) would commit a second time. The bench also checks that the top page bits are truncated, that out-of-range pages drop their writes, and that foreign-device traffic leaves every piece of state untouched. A reference model compares the read data and the internal write bus on every clock.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  // Class of one access strobe after device and register decode
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_FOREIGN,
    ACC_PAGE,
    ACC_LOW,
    ACC_HIGH,
    ACC_RSVD
  } acc_kind_e;
endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
#(
  parameter int          ID_W     = 5,
  parameter int          IDX_W    = 4,
  parameter logic [4:0]  DEV_ADDR = 5'h1F,
  parameter logic [4:0]  PAGE_REG = 5'h1F,
  parameter logic [4:0]  HIGH_REG = 5'h10
) (
  input  logic            req,
  input  logic [ID_W-1:0] phy,
  input  logic [ID_W-1:0] rnum,
  output acc_kind_e       kind
);
  localparam int LOW_COUNT = 1 << IDX_W;

  function automatic logic is_low(input logic [ID_W-1:0] r);
    return r < ID_W'(LOW_COUNT);
  endfunction

  always_comb begin
    if (!req)                 kind = ACC_IDLE;
    else if (phy != DEV_ADDR) kind = ACC_FOREIGN;
    else if (rnum == PAGE_REG) kind = ACC_PAGE;
    else if (is_low(rnum))    kind = ACC_LOW;
    else if (rnum == HIGH_REG) kind = ACC_HIGH;
    else                      kind = ACC_RSVD;
  end
endmodule

// File: rtl/mpb_stage.sv
module mpb_stage
  import mpb_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  acc_kind_e                  kind,
  input  logic                       write,
  input  logic [IDX_W-1:0]           idx,
  input  logic [HALF_W-1:0]          wdata,
  input  logic [2*HALF_W-1:0]        fetched,
  output logic [PAGE_W+IDX_W-1:0]    fetch_addr,
  output logic                       commit_we,
  output logic [PAGE_W+IDX_W-1:0]    commit_addr,
  output logic [2*HALF_W-1:0]        commit_data,
  output logic [HALF_W-1:0]          rdata
);
  localparam int WADDR_W = PAGE_W + IDX_W;

  function automatic logic [WADDR_W-1:0] word_addr(input logic [PAGE_W-1:0] pg,
                                                   input logic [IDX_W-1:0] ix);
    return {pg, ix};
  endfunction

  logic [PAGE_W-1:0]  page_q;
  logic [HALF_W-1:0]  lo_q;
  logic [WADDR_W-1:0] lo_addr_q;
  logic               armed_q;
  logic [HALF_W-1:0]  hi_q;
  logic [HALF_W-1:0]  rd_q;

  assign fetch_addr  = word_addr(page_q, idx);
  assign commit_we   = (kind == ACC_HIGH) && write && armed_q;
  assign commit_addr = lo_addr_q;
  assign commit_data = {wdata, lo_q};
  assign rdata       = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= '0;
      lo_q      <= '0;
      lo_addr_q <= '0;
      armed_q   <= 1'b0;
      hi_q      <= '0;
      rd_q      <= '0;
    end else begin
      unique case (kind)
        ACC_FOREIGN: if (!write) rd_q <= '1;
        ACC_PAGE: begin
          if (write) page_q <= wdata[PAGE_W-1:0];
          else       rd_q   <= HALF_W'(page_q);
        end
        ACC_LOW: begin
          if (write) begin
            lo_q      <= wdata;
            lo_addr_q <= fetch_addr;
            armed_q   <= 1'b1;
          end else begin
            rd_q <= fetched[HALF_W-1:0];
            hi_q <= fetched[2*HALF_W-1:HALF_W];
          end
        end
        ACC_HIGH: begin
          if (write) armed_q <= 1'b0;
          else       rd_q    <= hi_q;
        end
        ACC_RSVD: if (!write) rd_q <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mpb_regfile.sv
module mpb_regfile #(
  parameter int WORDS   = 32,
  parameter int WADDR_W = 14,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [WADDR_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int                 IDXB  = $clog2(WORDS);
  localparam logic [WADDR_W:0]   LIMIT = (WADDR_W+1)'(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic w_in, r_in;

  assign w_in  = {1'b0, waddr} < LIMIT;
  assign r_in  = {1'b0, raddr} < LIMIT;
  assign rdata = r_in ? mem[raddr[IDXB-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we && w_in) begin
      mem[waddr[IDXB-1:0]] <= wdata;
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int         ID_W     = 5,
  parameter int         PAGE_W   = 10,
  parameter int         IDX_W    = 4,
  parameter int         HALF_W   = 16,
  parameter int         WORDS    = 32,
  parameter logic [4:0] DEV_ADDR = 5'h1F,
  parameter logic [4:0] PAGE_REG = 5'h1F,
  parameter logic [4:0] HIGH_REG = 5'h10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mdio_req,
  input  logic                          mdio_wr,
  input  logic [ID_W-1:0]               mdio_phy,
  input  logic [ID_W-1:0]               mdio_reg,
  input  logic [HALF_W-1:0]             mdio_wdata,
  output logic [HALF_W-1:0]             mdio_rdata,
  output logic                          int_we,
  output logic [PAGE_W+IDX_W+1:0]       int_addr,
  output logic [2*HALF_W-1:0]           int_wdata
);
  localparam int WADDR_W = PAGE_W + IDX_W;
  localparam int WORD_W  = 2 * HALF_W;

  acc_kind_e          kind;
  logic [WADDR_W-1:0] fetch_addr;
  logic [WADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0]  fetched;

  mpb_decode #(
    .ID_W(ID_W), .IDX_W(IDX_W),
    .DEV_ADDR(DEV_ADDR), .PAGE_REG(PAGE_REG), .HIGH_REG(HIGH_REG)
  ) u_decode (
    .req(mdio_req), .phy(mdio_phy), .rnum(mdio_reg), .kind(kind)
  );

  mpb_stage #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .kind(kind), .write(mdio_wr),
    .idx(mdio_reg[IDX_W-1:0]), .wdata(mdio_wdata), .fetched(fetched),
    .fetch_addr(fetch_addr), .commit_we(int_we), .commit_addr(commit_addr),
    .commit_data(int_wdata), .rdata(mdio_rdata)
  );

  mpb_regfile #(.WORDS(WORDS), .WADDR_W(WADDR_W), .DATA_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(int_we), .waddr(commit_addr),
    .wdata(int_wdata), .raddr(fetch_addr), .rdata(fetched)
  );

  assign int_addr = {commit_addr, 2'b00};
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int         ID_W     = 5,
  parameter int         HALF_W   = 16,
  parameter int         AW       = 16,
  parameter logic [4:0] DEV_ADDR = 5'h1F,
  parameter logic [4:0] PAGE_REG = 5'h1F,
  parameter logic [4:0] HIGH_REG = 5'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_req,
  input logic              mdio_wr,
  input logic [ID_W-1:0]   mdio_phy,
  input logic [ID_W-1:0]   mdio_reg,
  input logic [HALF_W-1:0] mdio_rdata,
  input logic              int_we,
  input logic [AW-1:0]     int_addr
);
  logic rd_strobe, rsvd_read;
  assign rd_strobe = mdio_req && !mdio_wr;
  assign rsvd_read = rd_strobe && mdio_phy == DEV_ADDR &&
                     mdio_reg > HIGH_REG && mdio_reg != PAGE_REG;

  a_r2_foreign_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && mdio_phy != DEV_ADDR |=> mdio_rdata == '1);

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(mdio_rdata));

  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    int_we |=> !int_we);

  a_r5_commit_on_high_write: assert property (@(posedge clk) disable iff (!rst_n)
    int_we |-> mdio_req && mdio_wr && mdio_phy == DEV_ADDR && mdio_reg == HIGH_REG);

  a_r9_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_read |=> mdio_rdata == '0);
endmodule

bind mdio_page_bridge mpb_checker #(
  .ID_W(ID_W), .HALF_W(HALF_W), .AW(PAGE_W+IDX_W+2),
  .DEV_ADDR(DEV_ADDR), .PAGE_REG(PAGE_REG), .HIGH_REG(HIGH_REG)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
  .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_rdata(mdio_rdata),
  .int_we(int_we), .int_addr(int_addr)
);

// File: tb/test_mdio_page_bridge.sv
module test_mdio_page_bridge;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, wr = 0;
  logic [4:0]  phy = 0, rg = 0;
  logic [15:0] wd = 0;
  logic [15:0] rdata;
  logic        we;
  logic [15:0] addr;
  logic [31:0] wword;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rst_n(rst_n), .mdio_req(req), .mdio_wr(wr), .mdio_phy(phy),
    .mdio_reg(rg), .mdio_wdata(wd), .mdio_rdata(rdata), .int_we(we),
    .int_addr(addr), .int_wdata(wword)
  );

  // Behavioural reference model
  int unsigned m_mem [int];
  int m_page = 0, m_lo = 0, m_lo_word = 0, m_hi = 0, m_rd = 0;
  bit m_armed = 0;

  function automatic int unsigned m_word(int w);
    if (w < 32 && m_mem.exists(w)) return m_mem[w];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n && req) begin
      if (phy != 5'h1F) begin
        if (!wr) m_rd = 16'hFFFF;
      end else if (rg == 5'h1F) begin
        if (wr) m_page = wd % 1024; else m_rd = m_page;
      end else if (rg < 16) begin
        if (wr) begin
          m_lo = wd; m_lo_word = m_page * 16 + rg; m_armed = 1;
        end else begin
          m_rd = m_word(m_page * 16 + rg) & 16'hFFFF;
          m_hi = m_word(m_page * 16 + rg) >> 16;
        end
      end else if (rg == 5'h10) begin
        if (wr) begin
          if (m_armed && m_lo_word < 32) m_mem[m_lo_word] = (wd << 16) | m_lo;
          m_armed = 0;
        end else m_rd = m_hi;
      end else begin
        if (!wr) m_rd = 0;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      bit e_we;
      e_we = req && wr && phy == 5'h1F && rg == 5'h10 && m_armed;
      n_chk++;
      if (rdata !== 16'(m_rd)) begin
        n_fail++;
        $display("FAIL %s model rdata got %h exp %h", phase, rdata, 16'(m_rd));
      end
      n_chk++;
      if (we !== e_we) begin
        n_fail++;
        $display("FAIL %s model int_we got %b exp %b", phase, we, e_we);
      end
      if (e_we) begin
        n_chk++;
        if (addr !== 16'(m_lo_word * 4) || wword !== {wd, 16'(m_lo)}) begin
          n_fail++;
          $display("FAIL %s model commit got %h/%h exp %h/%h", phase, addr, wword,
                   16'(m_lo_word * 4), {wd, 16'(m_lo)});
        end
      end
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // One strobe: bus seen during the strobe, read data after its edge
  logic        s_we;
  logic [15:0] s_addr;
  logic [31:0] s_word;
  task automatic acc(input logic w, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d);
    @(negedge clk);
    req = 1; wr = w; phy = p; rg = r; wd = d;
    #5;
    s_we = we; s_addr = addr; s_word = wword;
    @(negedge clk);
    req = 0; wr = 0;
    #1;
  endtask

  task automatic wrt(input logic [4:0] r, input logic [15:0] d);
    acc(1, 5'h1F, r, d);
  endtask
  task automatic rd(input logic [4:0] r);
    acc(0, 5'h1F, r, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check(rdata, 0, "R1 reset rdata");
    rd(5'h10); check(rdata, 0, "R1 latched high after reset");
    rd(5'h1F); check(rdata, 0, "R1 page after reset");

    phase = "R3";
    wrt(5'h1F, 16'hFFFF); rd(5'h1F); check(rdata, 16'h03FF, "R3 page truncation");
    wrt(5'h1F, 16'h0001); rd(5'h1F); check(rdata, 16'h0001, "R3 page readback");

    phase = "R5";
    wrt(5'h1F, 0);
    wrt(5'h03, 16'hBEEF);
    check(s_we, 0, "R5 low write does not commit");
    wrt(5'h10, 16'hDEAD);
    check(s_we, 1, "R5 commit strobe");
    check(s_addr, 16'h000C, "R4 address page0 idx3");
    check(s_word, 32'hDEADBEEF, "R5 commit word");
    rd(5'h03); check(rdata, 16'hBEEF, "R8 low read");
    rd(5'h10); check(rdata, 16'hDEAD, "R8 high read");

    phase = "R4";
    wrt(5'h1F, 1); wrt(5'h02, 16'h5A5A); wrt(5'h10, 16'hA5A5);
    check(s_addr, 16'h0048, "R4 address page1 idx2");

    phase = "R6";
    wrt(5'h10, 16'h7777);
    check(s_we, 0, "R6 repeated high write ignored");
    rd(5'h02); rd(5'h10); check(rdata, 16'hA5A5, "R6 word unchanged");

    phase = "R7";
    wrt(5'h05, 16'h1111); wrt(5'h1F, 0); wrt(5'h10, 16'h2222);
    check(s_addr, 16'h0054, "R7 latched commit address");
    wrt(5'h1F, 1); rd(5'h05); check(rdata, 16'h1111, "R7 word at old page");

    phase = "R8";
    wrt(5'h05, 16'h3333); wrt(5'h10, 16'h4444);
    rd(5'h10); check(rdata, 16'h2222, "R8 latched half survives rewrite");
    rd(5'h05); rd(5'h10); check(rdata, 16'h4444, "R8 fresh fetch");

    phase = "R11";
    repeat (3) @(negedge clk);
    #1 check(rdata, 16'h4444, "R11 idle hold");
    wrt(5'h1F, 1); check(rdata, 16'h4444, "R11 hold through write");

    phase = "R2";
    acc(0, 5'h00, 5'h05, 0); check(rdata, 16'hFFFF, "R2 foreign read");
    acc(1, 5'h03, 5'h1F, 16'h0007);
    acc(1, 5'h1E, 5'h06, 16'h9999);
    acc(1, 5'h01, 5'h10, 16'h8888); check(s_we, 0, "R2 foreign high write");
    rd(5'h1F); check(rdata, 16'h0001, "R2 page untouched");
    rd(5'h06); check(rdata, 0, "R2 foreign low not staged");

    phase = "R9";
    wrt(5'h12, 16'hCAFE); rd(5'h12); check(rdata, 0, "R9 reserved reg");
    rd(5'h1E); check(rdata, 0, "R9 reserved top");

    phase = "R10";
    wrt(5'h1F, 2); wrt(5'h00, 16'h1234); wrt(5'h10, 16'h5678);
    check(s_we, 1, "R10 commit strobe out of range");
    check(s_addr, 16'h0080, "R4 address page2");
    rd(5'h00); check(rdata, 0, "R10 out-of-range reads zero");
    rd(5'h10); check(rdata, 0, "R10 out-of-range high zero");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule